// File: doc/BRIEF.md
# Pointer-addressed I2C slave with a 32-byte shared memory

This block is an I2C slave that exposes a small byte memory to an external bus master. After its own address with the write direction, the master sends one byte that sets an internal location pointer. Every further byte it writes is stored at the pointer, and the pointer then advances. A read transfer returns bytes starting at the current pointer and advances after each byte. The pointer wraps at the end of the memory. Data bytes are acknowledged by hardware, and the clock line is never held low during data.

A local port lets on-chip logic preload bytes for the master to fetch and collect bytes the master has deposited. A one-cycle pulse marks each stored byte, and another marks the stop condition that closes a transfer addressed to this slave.

Address recognition has two settings. With hardware compare on, the slave acknowledges a matching 7-bit address and ignores any other address. With it off, the slave holds SCL low after the address byte, raises a pulse, and shows the received byte. It then waits for local logic to accept or refuse the address.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset, sda_oe, scl_oe, wr_done, stop_seen and addr_irq are 0 and cpu_rdata reads 0x00. Every memory location holds 0x00.
- R2: With hw_addr_en=1, an address byte whose upper 7 bits equal own_addr is acknowledged by driving SDA low in the ninth clock. Any other address is not acknowledged, and the bytes that follow up to the next start or stop neither change the memory nor pulse wr_done.
- R3: In a write transfer, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increases by one.
- R4: A read transfer sends the byte at the current pointer, MSB first. After each byte the pointer increases by one. When the master acknowledges, the next byte follows.
- R5: The pointer wraps from 31 to 0. A pointer byte is reduced modulo 32, so only its low 5 bits count. A repeated start keeps the pointer.
- R6: Bytes written through the local port (cpu_we, cpu_addr, cpu_wdata) are the bytes the master reads. cpu_rdata gives the byte at cpu_addr one clock after cpu_addr is applied.
- R7: With hw_addr_en=1 the slave never drives SCL low.
- R8: Every data byte written by the master is acknowledged, with no local action.
- R9: With hw_addr_en=0, the slave holds SCL low after each address byte and pulses addr_irq. addr_byte shows the received byte, with the direction bit in bit 0. SCL stays low until cpu_ack_valid is seen. Then cpu_ack_accept=1 acknowledges the address and cpu_ack_accept=0 refuses it. Data bytes are never stalled.
- R10: If the bus and the local port write the same location in one clock, the bus byte is stored. cpu_rdata in the next clock shows the bus byte.
- R11: wr_done pulses once for each stored data byte and not for the pointer byte. stop_seen pulses once at the stop that ends a transfer addressed to this slave.
- R12: A read ends when the master does not acknowledge a byte. The slave then releases SDA and waits for the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 holds SCL low (address stall only) |
| hw_addr_en | input | 1 | 1 selects hardware address compare |
| own_addr | input | 7 | Slave address for hardware compare |
| addr_irq | output | 1 | One-cycle pulse when an address byte is stalled |
| addr_byte | output | 8 | Last stalled address byte, direction in bit 0 |
| cpu_ack_valid | input | 1 | Local answer to a stalled address |
| cpu_ack_accept | input | 1 | 1 accepts, 0 refuses the stalled address |
| cpu_addr | input | 5 | Local port location |
| cpu_we | input | 1 | Local port write enable |
| cpu_wdata | input | 8 | Local port write data |
| cpu_rdata | output | 8 | Local port read data, registered |
| wr_done | output | 1 | One-cycle pulse per byte stored by the master |
| stop_seen | output | 1 | One-cycle pulse at stop of an addressed transfer |

## Verification
A wrong pointer shows up at the very next byte. The master reads a byte from the wrong location, or a local read finds a written byte one place off. Wrap and modulo errors show up at locations 31 and 0. An acknowledge or release in the wrong state shows up within one bit time as a wrong ninth-clock level seen by the master model. A hold on SCL at the wrong moment stalls that model right away. A bypass or collision error shows up in cpu_rdata in the clock after the bus write.

// File: rtl/i2cmem_pkg.sv
// Package: shared constants and the transfer engine state type.
// Assumes 7-bit I2C addressing and byte-wide memory.
package i2cmem_pkg;
    localparam int I2C_AW = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_AACK,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } eng_state_t;
endpackage

// File: rtl/i2c_pin_sampler.sv
// Module: synchronises SCL/SDA into clk and derives edge, start and stop pulses.
// Assumes clk is several times faster than SCL.
module i2c_pin_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [SYNC-1:0] scl_ff;
    logic [SYNC-1:0] sda_ff;
    logic            scl_d;
    logic            sda_d;
    logic            scl_s;

    // Synchroniser chains plus one delayed copy; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC-2:0], sda_i};
            scl_d  <= scl_ff[SYNC-1];
            sda_d  <= sda_ff[SYNC-1];
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        scl_s    = scl_ff[SYNC-1];
        sda_s    = sda_ff[SYNC-1];
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        start_p  = scl_s & scl_d & sda_d & ~sda_s;
        stop_p   = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/regfile_mem.sv
// Module: byte memory with a bus port (write + combinational read) and a
// local port (write + registered read). A bus write beats a same-cycle local
// write; the local read bypasses a same-cycle bus write to its location.
module regfile_mem #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Storage: local write first, bus write last so it takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (cpu_we) mem[cpu_addr] <= cpu_wdata;
            if (bus_we) mem[bus_addr] <= bus_wdata;
        end
    end

    // Local registered read with bus-write bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_rdata <= '0;
        else if (bus_we && bus_addr == cpu_addr) cpu_rdata <= bus_wdata;
        else cpu_rdata <= mem[cpu_addr];
    end

    // Bus read path used when loading a byte to transmit.
    always_comb bus_rdata = mem[bus_addr];

    // R10
    bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> mem[$past(bus_addr)] == $past(bus_wdata));
    // R10
    rd_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == cpu_addr) |=> cpu_rdata == $past(bus_wdata));
endmodule

// File: rtl/i2c_xfer_engine.sv
// Module: bit/byte transfer engine of the slave. Handles address compare
// (hardware or local), pointer loading, auto-ACKed writes and reads.
// Assumes synchronised edge pulses from i2c_pin_sampler.
module i2c_xfer_engine
    import i2cmem_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              hw_addr_en,
    input  logic [I2C_AW-1:0] own_addr,
    input  logic              cpu_ack_valid,
    input  logic              cpu_ack_accept,
    input  logic [DW-1:0]     mem_rdata,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              addr_irq,
    output logic [DW-1:0]     addr_byte,
    output logic              wr_done,
    output logic              stop_seen
);
    localparam logic [CW-1:0] BITS  = CW'(DW);
    localparam logic [CW-1:0] LASTB = CW'(DW - 1);

    eng_state_t    state;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] txreg;
    logic [AW-1:0] ptr;
    logic          ptr_phase;
    logic          rw;
    logic          m_ack;
    logic          active;
    logic          sda_oe_q;
    logic          scl_oe_q;
    logic          addr_irq_q;
    logic [DW-1:0] addr_byte_q;
    logic          wr_done_q;
    logic          stop_q;
    logic          byte_end;
    logic          addr_match;

    // Byte-boundary and address-match decode.
    always_comb begin
        byte_end   = scl_fall && bitcnt == BITS && !start_p && !stop_p;
        addr_match = shreg[DW-1:DW-I2C_AW] == own_addr;
        bus_we     = state == ST_RX && byte_end && !ptr_phase;
        bus_addr   = ptr;
        bus_wdata  = shreg;
    end

    // Main transfer state machine; stop and start override any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bitcnt      <= '0;
            shreg       <= '0;
            txreg       <= '0;
            ptr         <= '0;
            ptr_phase   <= 1'b0;
            rw          <= 1'b0;
            m_ack       <= 1'b0;
            active      <= 1'b0;
            sda_oe_q    <= 1'b0;
            scl_oe_q    <= 1'b0;
            addr_irq_q  <= 1'b0;
            addr_byte_q <= '0;
            wr_done_q   <= 1'b0;
            stop_q      <= 1'b0;
        end else begin
            addr_irq_q <= 1'b0;
            wr_done_q  <= 1'b0;
            stop_q     <= 1'b0;
            if (stop_p) begin
                state    <= ST_IDLE;
                sda_oe_q <= 1'b0;
                scl_oe_q <= 1'b0;
                stop_q   <= active;
                active   <= 1'b0;
            end else if (start_p) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_oe_q <= 1'b0;
                scl_oe_q <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_end) begin
                            rw <= shreg[0];
                            if (hw_addr_en) begin
                                if (addr_match) begin
                                    state     <= ST_AACK;
                                    sda_oe_q  <= 1'b1;
                                    active    <= 1'b1;
                                    ptr_phase <= ~shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state       <= ST_HOLD;
                                scl_oe_q    <= 1'b1;
                                addr_irq_q  <= 1'b1;
                                addr_byte_q <= shreg;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (cpu_ack_valid) begin
                            scl_oe_q <= 1'b0;
                            if (cpu_ack_accept) begin
                                state     <= ST_AACK;
                                sda_oe_q  <= 1'b1;
                                active    <= 1'b1;
                                ptr_phase <= ~rw;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state    <= ST_TX;
                                txreg    <= mem_rdata;
                                sda_oe_q <= ~mem_rdata[DW-1];
                            end else begin
                                state    <= ST_RX;
                                sda_oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_end) begin
                            state    <= ST_RXACK;
                            sda_oe_q <= 1'b1;
                            if (ptr_phase) begin
                                ptr       <= shreg[AW-1:0];
                                ptr_phase <= 1'b0;
                            end else begin
                                ptr       <= ptr + 1'b1;
                                wr_done_q <= 1'b1;
                            end
                        end
                    end
                    ST_RXACK: begin
                        if (scl_fall) begin
                            state    <= ST_RX;
                            sda_oe_q <= 1'b0;
                            bitcnt   <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == LASTB) begin
                                state    <= ST_TXACK;
                                sda_oe_q <= 1'b0;
                                ptr      <= ptr + 1'b1;
                            end else begin
                                txreg    <= {txreg[DW-2:0], 1'b0};
                                sda_oe_q <= ~txreg[DW-2];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                state    <= ST_TX;
                                bitcnt   <= '0;
                                txreg    <= mem_rdata;
                                sda_oe_q <= ~mem_rdata[DW-1];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output drive from registered state.
    always_comb begin
        sda_oe    = sda_oe_q;
        scl_oe    = scl_oe_q;
        addr_irq  = addr_irq_q;
        addr_byte = addr_byte_q;
        wr_done   = wr_done_q;
        stop_seen = stop_q;
    end

    // R7
    no_hw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe_q) |-> !hw_addr_en);
    // R9
    hold_until_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe_q && !cpu_ack_valid) |=> scl_oe_q);
    // R8
    data_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> sda_oe_q);
    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> ptr == AW'($past(ptr) + 1));
    // R12
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TXACK && scl_fall && !m_ack && !start_p && !stop_p)
        |=> (state == ST_IDLE && !sda_oe_q));
endmodule

// File: rtl/i2c_regfile_slave.sv
// Module: top of the pointer-addressed I2C slave with a shared byte memory.
// Assumes open-drain pads outside: *_oe=1 pulls the line low.
module i2c_regfile_slave
    import i2cmem_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int SYNC  = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              scl_oe,
    input  logic              hw_addr_en,
    input  logic [I2C_AW-1:0] own_addr,
    output logic              addr_irq,
    output logic [DW-1:0]     addr_byte,
    input  logic              cpu_ack_valid,
    input  logic              cpu_ack_accept,
    input  logic [AW-1:0]     cpu_addr,
    input  logic              cpu_we,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              wr_done,
    output logic              stop_seen
);
    logic          sda_s;
    logic          scl_rise;
    logic          scl_fall;
    logic          start_p;
    logic          stop_p;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;

    i2c_pin_sampler #(.SYNC(SYNC)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2c_xfer_engine #(.DEPTH(DEPTH), .DW(DW)) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .sda_s          (sda_s),
        .scl_rise       (scl_rise),
        .scl_fall       (scl_fall),
        .start_p        (start_p),
        .stop_p         (stop_p),
        .hw_addr_en     (hw_addr_en),
        .own_addr       (own_addr),
        .cpu_ack_valid  (cpu_ack_valid),
        .cpu_ack_accept (cpu_ack_accept),
        .mem_rdata      (bus_rdata),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .sda_oe         (sda_oe),
        .scl_oe         (scl_oe),
        .addr_irq       (addr_irq),
        .addr_byte      (addr_byte),
        .wr_done        (wr_done),
        .stop_seen      (stop_seen)
    );

    regfile_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata)
    );
endmodule

// File: tb/i2c_regfile_slave_bench.sv
// Bench: I2C master model plus scoreboard of bytes expected from master reads.
module i2c_regfile_slave_bench;
    localparam int Q = 10;
    localparam logic [6:0] OWN = 7'h3A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       scl_i, sda_i, sda_oe, scl_oe;
    logic       hw_addr_en = 1'b1;
    logic       addr_irq;
    logic [7:0] addr_byte;
    logic       cpu_ack_valid = 1'b0;
    logic       cpu_ack_accept = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       wr_done, stop_seen;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int stop_cnt = 0;
    int irq_cnt = 0;
    int stall_cnt = 0;
    bit hw_stall_seen = 0;
    bit accept_policy = 1;
    logic [7:0] seen_abyte = '0;
    logic [7:0] exp_mem [32];
    logic [7:0] exp_q [$];
    logic [7:0] last_rx;
    event rx_ev;
    bit coll_arm = 0;
    bit coll_seen = 0;
    logic [7:0] coll_val = '0;

    always #5 clk = ~clk;

    assign scl_i = m_scl & ~scl_oe;
    assign sda_i = m_sda & ~sda_oe;

    i2c_regfile_slave u_i2c_regfile_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .hw_addr_en(hw_addr_en),
        .own_addr(OWN), .addr_irq(addr_irq), .addr_byte(addr_byte),
        .cpu_ack_valid(cpu_ack_valid), .cpu_ack_accept(cpu_ack_accept),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .wr_done(wr_done), .stop_seen(stop_seen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_i) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1; wq(Q); m_scl = 1; wait_scl_high(); wq(Q);
        m_sda = 0; wq(Q); m_scl = 0; wq(Q);
    endtask

    task automatic m_stop();
        m_sda = 0; wq(Q); m_scl = 1; wait_scl_high(); wq(Q);
        m_sda = 1; wq(Q);
    endtask

    task automatic wr_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1; wait_scl_high(); wq(Q);
        m_scl = 0; wq(Q);
    endtask

    task automatic rd_bit(output logic b);
        m_sda = 1; wq(Q); m_scl = 1; wait_scl_high(); wq(Q);
        b = sda_i; m_scl = 0; wq(Q);
    endtask

    // Returns 1 in nack when the ninth-clock level was high.
    task automatic wr_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) wr_bit(v[i]);
        rd_bit(nack);
    endtask

    task automatic rd_byte(input logic give_nack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) rd_bit(v[i]);
        wr_bit(give_nack);
        last_rx = v;
        ->rx_ev;
    endtask

    task automatic cpu_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_we = 1;
        @(negedge clk); cpu_we = 0;
        exp_mem[a] = d;
    endtask

    task automatic cpu_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); cpu_addr = a;
        @(negedge clk); d = cpu_rdata;
    endtask

    // Driver side of the scoreboard: queue bytes the master should read.
    task automatic expect_rd(input logic [4:0] a);
        exp_q.push_back(exp_mem[a]);
    endtask

    // Monitor: compare each byte the master reads against the queue (R4, R6).
    initial forever begin
        @(rx_ev);
        if (exp_q.size() == 0) check(0, "R4 unexpected byte", last_rx, 0);
        else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(last_rx == e, "R4/R6 read byte", last_rx, e);
        end
    end

    // Port event counters and the local address responder.
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (wr_done) wr_cnt++;
            if (stop_seen) stop_cnt++;
            if (scl_oe && hw_addr_en) hw_stall_seen = 1;
            if (coll_arm && wr_done && !coll_seen) begin
                coll_seen = 1; coll_val = cpu_rdata;
            end
            if (addr_irq) begin
                irq_cnt++;
                seen_abyte = addr_byte;
                wq(20);
                if (scl_oe) stall_cnt++;
                cpu_ack_accept = accept_policy; cpu_ack_valid = 1;
                @(negedge clk); cpu_ack_valid = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic n;
        logic [7:0] d;
        for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
        wq(4); rst_n = 1; wq(2);
        // R1 reset state
        check(sda_oe == 0 && scl_oe == 0 && wr_done == 0 && stop_seen == 0 && addr_irq == 0,
              "R1 outputs idle", {sda_oe, scl_oe, wr_done, stop_seen, addr_irq}, 0);
        cpu_rd(5'd9, d);
        check(d == 8'h00, "R1 memory cleared", d, 0);

        for (int i = 0; i < 32; i++) cpu_wr(5'(i), 8'hA0 + 8'(i));

        // R2 R3 R8 R11: write pointer 4, then three data bytes
        wr_cnt = 0; stop_cnt = 0;
        m_start();
        wr_byte({OWN, 1'b0}, n); check(n == 0, "R2 own address acked", n, 0);
        wr_byte(8'h04, n);       check(n == 0, "R8 pointer byte acked", n, 0);
        wr_byte(8'h11, n);       check(n == 0, "R8 data acked", n, 0);
        wr_byte(8'h22, n);
        wr_byte(8'h33, n);       check(n == 0, "R8 last data acked", n, 0);
        m_stop(); wq(5);
        exp_mem[4] = 8'h11; exp_mem[5] = 8'h22; exp_mem[6] = 8'h33;
        check(wr_cnt == 3, "R11 wr_done count", wr_cnt, 3);
        check(stop_cnt == 1, "R11 stop_seen count", stop_cnt, 1);
        cpu_rd(5'd4, d); check(d == 8'h11, "R3 loc4", d, 8'h11);
        cpu_rd(5'd6, d); check(d == 8'h33, "R3 loc6", d, 8'h33);
        cpu_rd(5'd7, d); check(d == 8'hA7, "R3 loc7 untouched", d, 8'hA7);

        // R4 R6 R12: read continues at pointer 7, NACK on third byte
        m_start();
        wr_byte({OWN, 1'b1}, n); check(n == 0, "R2 read address acked", n, 0);
        expect_rd(5'd7); rd_byte(0);
        expect_rd(5'd8); rd_byte(0);
        expect_rd(5'd9); rd_byte(1);
        wq(2);
        check(sda_oe == 0, "R12 SDA released after NACK", sda_oe, 0);
        m_stop();
        m_start();
        wr_byte({OWN, 1'b1}, n);
        expect_rd(5'd10); rd_byte(1);
        m_stop();

        // R5: pointer 0x3F reduces to 31, write wraps to 0
        m_start();
        wr_byte({OWN, 1'b0}, n); wr_byte(8'h3F, n);
        wr_byte(8'h5A, n); wr_byte(8'h5B, n);
        m_stop();
        exp_mem[31] = 8'h5A; exp_mem[0] = 8'h5B;
        cpu_rd(5'd31, d); check(d == 8'h5A, "R5 loc31", d, 8'h5A);
        cpu_rd(5'd0, d);  check(d == 8'h5B, "R5 wrap to loc0", d, 8'h5B);
        m_start();
        wr_byte({OWN, 1'b0}, n); wr_byte(8'h25, n); wr_byte(8'h77, n);
        m_stop();
        exp_mem[5] = 8'h77;
        cpu_rd(5'd5, d); check(d == 8'h77, "R5 pointer modulo 32", d, 8'h77);
        // R5: read wrap across a repeated start
        m_start();
        wr_byte({OWN, 1'b0}, n); wr_byte(8'd31, n);
        m_start();
        wr_byte({OWN, 1'b1}, n);
        expect_rd(5'd31); rd_byte(0);
        expect_rd(5'd0);  rd_byte(1);
        m_stop();

        // R2: foreign address ignored
        wr_cnt = 0; stop_cnt = 0;
        m_start();
        wr_byte(8'h22, n); check(n == 1, "R2 foreign address not acked", n, 1);
        wr_byte(8'h02, n); wr_byte(8'hEE, n);
        check(n == 1, "R2 foreign data not acked", n, 1);
        m_stop(); wq(5);
        cpu_rd(5'd2, d); check(d == 8'hA2, "R2 memory unchanged", d, 8'hA2);
        check(wr_cnt == 0 && stop_cnt == 0, "R2 no pulses", wr_cnt + stop_cnt, 0);

        // R10: local write held on loc12 while the bus writes it
        @(negedge clk); cpu_addr = 5'd12; cpu_wdata = 8'h5C; cpu_we = 1; coll_arm = 1;
        m_start();
        wr_byte({OWN, 1'b0}, n); wr_byte(8'd12, n); wr_byte(8'hB4, n);
        m_stop();
        @(negedge clk); cpu_we = 0; coll_arm = 0;
        check(coll_seen && coll_val == 8'hB4, "R10 bus wins collision", coll_val, 8'hB4);
        exp_mem[12] = 8'h5C;

        check(!hw_stall_seen, "R7 no SCL hold in hardware compare", hw_stall_seen, 0);

        // R9: local address compare, accept then refuse
        hw_addr_en = 0; accept_policy = 1; irq_cnt = 0; stall_cnt = 0; wr_cnt = 0;
        m_start();
        wr_byte({OWN, 1'b0}, n); check(n == 0, "R9 accepted address acked", n, 0);
        wr_byte(8'd20, n); wr_byte(8'h66, n); wr_byte(8'h67, n);
        check(n == 0, "R9 data auto acked", n, 0);
        m_stop();
        exp_mem[20] = 8'h66; exp_mem[21] = 8'h67;
        check(irq_cnt == 1 && stall_cnt == 1, "R9 one stall at address only", irq_cnt * 16 + stall_cnt, 8'h11);
        check(seen_abyte == {OWN, 1'b0}, "R9 addr_byte", seen_abyte, {OWN, 1'b0});
        cpu_rd(5'd21, d); check(d == 8'h67, "R9 data stored", d, 8'h67);
        accept_policy = 0;
        m_start();
        wr_byte({OWN, 1'b1}, n); check(n == 1, "R9 refused address not acked", n, 1);
        m_stop();
        check(irq_cnt == 2 && seen_abyte == {OWN, 1'b1}, "R9 second address byte", seen_abyte, {OWN, 1'b1});
        check(exp_q.size() == 0, "R4 all expected bytes read", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule